// File: doc/BRIEF.md
# Lockable Pad Delay Register Bank

This block is the register file of a pad delay controller. Software reaches it over a plain 32-bit request port: one request per cycle, with a byte offset, a write flag and write data. It answers each request one cycle later. The bank holds four things. A key-protected region lock word, which also carries a sticky error flag. Three read-only calibration words, whose values come from input pins fed by the calibration hardware. Three delay configuration words for every pad. Each pad word holds a 5-bit coarse element count and a 5-bit fine element count. The counts of every pad word leave the block on two wide output buses, which drive the delay lines.

Pad word writes are filtered twice. First, the whole region must have been opened with the correct 16-bit key. Second, the written word must carry a fixed 6-bit signature. A pad word can also be frozen through its own lock bit. A frozen word refuses updates that keep the bit set, and accepts an update that clears the bit. A write refused by the region lock or by a bad signature raises the sticky error flag, which software clears by writing a one to it.

Top module: `iodly_bank`

## Requirements
- R1: After reset the region is locked (offset 0x2C reads 0x0000AAAB). Every pad word reads 0x00029000 (signature 0x29 in bits 17:12, lock and counts zero). All count outputs are zero, the error flag is clear, and `rsp_ready` is low.
- R2: At offset 0x2C, writing 0xAAAA into bits 15:0 opens the region and writing 0xAAAB closes it. Any other value in bits 15:0 leaves the state unchanged. A read returns 0xAAAA when open and 0xAAAB when closed in bits 15:0, and the error flag in bit 16. Writing 1 to bit 16 clears the flag.
- R3: While the region is closed, a write to any pad word leaves that word unchanged and sets the error flag.
- R4: While the region is open, a pad word write whose bits 17:12 differ from 0x29 leaves the word unchanged and sets the error flag.
- R5: An accepted pad word write stores bit 10 (lock), bits 9:5 (coarse) and bits 4:0 (fine). A read returns those fields with 0x29 in bits 17:12 and zero in every other bit.
- R6: If a pad word's stored lock bit is 1, a write with bit 10 set leaves the word unchanged and does not set the error flag. A write with bit 10 clear is accepted in full.
- R7: Offset 0x14 reads {16'h0, period}. Offset 0x18 reads {coarse count, coarse reference}. Offset 0x1C reads {fine count, fine reference}. All of these come from the calibration inputs, and writes to these offsets have no effect.
- R8: Pad word k (k = 3*pad + slot) sits at offset 0x30 + 4*k, and the last one sits at 0xD1C. Its counts appear on `dly_coarse[5k+4:5k]` and `dly_fine[5k+4:5k]`.
- R9: Reads of unmapped offsets (0x00 to 0x10, 0x20 to 0x28, above 0xD1C) return zero. Writes to them change nothing and do not set the error flag.
- R10: `rsp_ready` is high in the cycle after each accepted request and low otherwise. `rsp_rdata` carries the read word for reads and zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset; bits 1:0 ignored |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| cal_period | input | 16 | Reference clock period from calibration |
| cal_coarse_ref | input | 16 | Coarse reference count |
| cal_coarse_cnt | input | 16 | Coarse delay count |
| cal_fine_ref | input | 16 | Fine reference count |
| cal_fine_cnt | input | 16 | Fine delay count |
| dly_coarse | output | 4140 | Coarse counts, 5 bits per pad word |
| dly_fine | output | 4140 | Fine counts, 5 bits per pad word |

## Verification
Two functions can meet in one request.

The first pair is a change of the region key and the clearing of the error flag, both carried by the same word at 0x2C. The bench writes 0x0001AAAA while the flag is set. It expects the read-back to show the region open and bit 16 clear. A later write of 0x00011234 must clear the flag while leaving the region state alone.

The second pair is the release of a frozen pad word and a new count setting, done in one write. The bench checks that a write keeping the lock bit set is refused without an error, and that the write clearing it lands with the new counts in the very next read.

// File: rtl/iodly_pkg.sv
package iodly_pkg;
  localparam int DATA_W      = 32;
  localparam int CODE_W      = 5;
  localparam int SIG_W       = 6;
  localparam int SIG_LSB     = 12;
  localparam int LOCK_BIT    = 10;
  localparam int COARSE_LSB  = 5;
  localparam int ERR_BIT     = 16;
  localparam logic [SIG_W-1:0] SIG_VALUE = 6'h29;
  localparam logic [15:0] KEY_OPEN = 16'hAAAA;
  localparam logic [15:0] KEY_SHUT = 16'hAAAB;
  // word indices (byte offset / 4)
  localparam int W_PERIOD   = 5;
  localparam int W_COARSE   = 6;
  localparam int W_FINE     = 7;
  localparam int W_LOCK     = 11;
  localparam int W_PIN_BASE = 12;

  typedef enum logic [2:0] {
    RK_NONE, RK_LOCK, RK_PERIOD, RK_COARSE, RK_FINE, RK_PIN
  } reg_kind_e;

  typedef struct packed {
    logic              lock;
    logic [CODE_W-1:0] coarse;
    logic [CODE_W-1:0] fine;
  } cell_t;

  localparam int CELL_W = $bits(cell_t);

  function automatic logic [DATA_W-1:0] cell_to_word(input cell_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SIG_LSB +: SIG_W]           = SIG_VALUE;
    w[LOCK_BIT]                   = c.lock;
    w[COARSE_LSB +: CODE_W]       = c.coarse;
    w[CODE_W-1:0]                 = c.fine;
    return w;
  endfunction

  function automatic cell_t word_to_cell(input logic [DATA_W-1:0] w);
    cell_t c;
    c.lock   = w[LOCK_BIT];
    c.coarse = w[COARSE_LSB +: CODE_W];
    c.fine   = w[CODE_W-1:0];
    return c;
  endfunction

  function automatic logic sig_ok(input logic [DATA_W-1:0] w);
    return w[SIG_LSB +: SIG_W] == SIG_VALUE;
  endfunction
endpackage

// File: rtl/iodly_addr_dec.sv
module iodly_addr_dec
  import iodly_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 828,
  parameter int IDX_W    = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  logic [31:0] word;
  logic [31:0] rel;

  always_comb begin
    word = 32'(addr[ADDR_W-1:2]);
    rel  = word - 32'(W_PIN_BASE);
    idx  = rel[IDX_W-1:0];
    if (word >= 32'(W_PIN_BASE) && rel < 32'(NUM_REGS)) kind = RK_PIN;
    else if (word == 32'(W_LOCK))   kind = RK_LOCK;
    else if (word == 32'(W_PERIOD)) kind = RK_PERIOD;
    else if (word == 32'(W_COARSE)) kind = RK_COARSE;
    else if (word == 32'(W_FINE))   kind = RK_FINE;
    else                            kind = RK_NONE;
  end
endmodule

// File: rtl/iodly_wr_gate.sv
module iodly_wr_gate
  import iodly_pkg::*;
(
  input  logic              wr_pin,
  input  logic              region_open,
  input  logic              stored_lock,
  input  logic [DATA_W-1:0] wdata,
  output logic              accept,
  output logic              err_locked,
  output logic              err_sig,
  output logic              hold_frozen
);
  logic good_sig;

  always_comb begin
    good_sig    = sig_ok(wdata);
    err_locked  = wr_pin && !region_open;
    err_sig     = wr_pin && region_open && !good_sig;
    hold_frozen = wr_pin && region_open && good_sig && stored_lock && wdata[LOCK_BIT];
    accept      = wr_pin && region_open && good_sig && !hold_frozen;
  end
endmodule

// File: rtl/iodly_lock_ctl.sv
module iodly_lock_ctl
  import iodly_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lock,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_err,
  output logic              region_open,
  output logic              err_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_open <= 1'b0;
    end else if (wr_lock) begin
      if (wdata[15:0] == KEY_OPEN)      region_open <= 1'b1;
      else if (wdata[15:0] == KEY_SHUT) region_open <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         err_flag <= 1'b0;
    else if (set_err)                   err_flag <= 1'b1;
    else if (wr_lock && wdata[ERR_BIT]) err_flag <= 1'b0;
  end
endmodule

// File: rtl/iodly_cell_array.sv
module iodly_cell_array
  import iodly_pkg::*;
#(
  parameter int NUM_REGS = 828,
  parameter int IDX_W    = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           widx,
  input  cell_t                      wcell,
  output logic [NUM_REGS*CELL_W-1:0] cells_flat
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_cell
    cell_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= '0;
      else if (we && widx == IDX_W'(k))         q <= wcell;
    end
    assign cells_flat[k*CELL_W +: CELL_W] = q;
  end
endmodule

// File: rtl/iodly_bank.sv
module iodly_bank
  import iodly_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_PINS = 276,
  parameter int REGS_PER_PIN = 3,
  localparam int NUM_REGS = NUM_PINS * REGS_PER_PIN,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [31:0]                  req_wdata,
  output logic                         rsp_ready,
  output logic [31:0]                  rsp_rdata,
  input  logic [15:0]                  cal_period,
  input  logic [15:0]                  cal_coarse_ref,
  input  logic [15:0]                  cal_coarse_cnt,
  input  logic [15:0]                  cal_fine_ref,
  input  logic [15:0]                  cal_fine_cnt,
  output logic [NUM_REGS*CODE_W-1:0]   dly_coarse,
  output logic [NUM_REGS*CODE_W-1:0]   dly_fine
);
  reg_kind_e               kind;
  logic [IDX_W-1:0]        idx;
  logic [NUM_REGS*CELL_W-1:0] cells_flat;
  cell_t                   cur_cell;
  logic                    wr_pin, wr_lock;
  logic                    region_open, err_flag;
  logic                    gate_accept, gate_err_locked, gate_err_sig, gate_hold;
  logic [31:0]             rd_word;

  iodly_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
    .addr(req_addr), .kind(kind), .idx(idx)
  );

  always_comb begin
    cur_cell = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (idx == IDX_W'(k)) cur_cell = cells_flat[k*CELL_W +: CELL_W];
  end

  assign wr_pin  = req_valid && req_write && (kind == RK_PIN);
  assign wr_lock = req_valid && req_write && (kind == RK_LOCK);

  iodly_wr_gate u_gate (
    .wr_pin(wr_pin), .region_open(region_open), .stored_lock(cur_cell.lock),
    .wdata(req_wdata), .accept(gate_accept), .err_locked(gate_err_locked),
    .err_sig(gate_err_sig), .hold_frozen(gate_hold)
  );

  iodly_lock_ctl u_lock (
    .clk(clk), .rst_n(rst_n), .wr_lock(wr_lock), .wdata(req_wdata),
    .set_err(gate_err_locked || gate_err_sig),
    .region_open(region_open), .err_flag(err_flag)
  );

  iodly_cell_array #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_cells (
    .clk(clk), .rst_n(rst_n), .we(gate_accept), .widx(idx),
    .wcell(word_to_cell(req_wdata)), .cells_flat(cells_flat)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_out
    cell_t c;
    assign c = cells_flat[k*CELL_W +: CELL_W];
    assign dly_coarse[k*CODE_W +: CODE_W] = c.coarse;
    assign dly_fine[k*CODE_W +: CODE_W]   = c.fine;
  end

  always_comb begin
    unique case (kind)
      RK_LOCK:   rd_word = {15'b0, err_flag, region_open ? KEY_OPEN : KEY_SHUT};
      RK_PERIOD: rd_word = {16'b0, cal_period};
      RK_COARSE: rd_word = {cal_coarse_cnt, cal_coarse_ref};
      RK_FINE:   rd_word = {cal_fine_cnt, cal_fine_ref};
      RK_PIN:    rd_word = cell_to_word(cur_cell);
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ready <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/iodly_chk.sv
module iodly_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_wdata,
  input logic        rsp_ready,
  input logic        wr_pin,
  input logic        wr_lock,
  input logic        region_open,
  input logic        err_flag,
  input logic        gate_accept,
  input logic        gate_err_sig
);
  // R10
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);
  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);
  // R3
  closed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pin && !region_open) |=> err_flag);
  // R4
  bad_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_err_sig |=> err_flag);
  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && req_wdata[15:0] == 16'hAAAA) |=> region_open);
  // R2
  key_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && req_wdata[15:0] == 16'hAAAB) |=> !region_open);
  // R5
  accept_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_accept |-> (region_open && req_wdata[17:12] == 6'h29));
endmodule

bind iodly_bank iodly_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wdata(req_wdata),
  .rsp_ready(rsp_ready), .wr_pin(wr_pin), .wr_lock(wr_lock),
  .region_open(region_open), .err_flag(err_flag),
  .gate_accept(gate_accept), .gate_err_sig(gate_err_sig)
);

// File: tb/sim_iodly_bank.sv
module sim_iodly_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 828;
  localparam int NV = 40;
  localparam int WATCHDOG = 20000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ready;
  logic [31:0] rsp_rdata;
  logic [NREG*5-1:0] dly_coarse, dly_fine;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iodly_bank u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .cal_period(16'h1234), .cal_coarse_ref(16'h0055),
    .cal_coarse_cnt(16'h00AA), .cal_fine_ref(16'h0066), .cal_fine_cnt(16'h0077),
    .dly_coarse(dly_coarse), .dly_fine(dly_fine)
  );

  // {write, offset, wdata, expected read, requirement}
  localparam logic [80:0] VECS [NV] = '{
    {1'b0,12'h02C,32'h0,32'h0000AAAB,4'd1},  // R1 closed at reset
    {1'b0,12'h030,32'h0,32'h00029000,4'd1},
    {1'b0,12'hD1C,32'h0,32'h00029000,4'd1},
    {1'b1,12'h030,32'h000290A5,32'h0,4'd3},  // R3 write while closed
    {1'b0,12'h030,32'h0,32'h00029000,4'd3},
    {1'b0,12'h02C,32'h0,32'h0001AAAB,4'd3},
    {1'b1,12'h02C,32'h0001AAAA,32'h0,4'd2},  // R2 open + clear error
    {1'b0,12'h02C,32'h0,32'h0000AAAA,4'd2},
    {1'b1,12'h030,32'hFFFE98A3,32'h0,4'd5},  // R5 stray bits dropped
    {1'b0,12'h030,32'h0,32'h000290A3,4'd5},
    {1'b1,12'h034,32'h0002A0FF,32'h0,4'd4},  // R4 bad signature
    {1'b0,12'h034,32'h0,32'h00029000,4'd4},
    {1'b0,12'h02C,32'h0,32'h0001AAAA,4'd4},
    {1'b1,12'h02C,32'h00011234,32'h0,4'd2},  // R2 clear, no key
    {1'b0,12'h02C,32'h0,32'h0000AAAA,4'd2},
    {1'b1,12'h038,32'h000297FF,32'h0,4'd5},
    {1'b0,12'h038,32'h0,32'h000297FF,4'd5},
    {1'b1,12'h038,32'h00029421,32'h0,4'd6},  // R6 frozen, kept lock
    {1'b0,12'h038,32'h0,32'h000297FF,4'd6},
    {1'b0,12'h02C,32'h0,32'h0000AAAA,4'd6},
    {1'b1,12'h038,32'h00029042,32'h0,4'd6},  // R6 release + new codes
    {1'b0,12'h038,32'h0,32'h00029042,4'd6},
    {1'b0,12'h014,32'h0,32'h00001234,4'd7},  // R7 calibration
    {1'b0,12'h018,32'h0,32'h00AA0055,4'd7},
    {1'b0,12'h01C,32'h0,32'h00770066,4'd7},
    {1'b1,12'h018,32'hFFFFFFFF,32'h0,4'd7},
    {1'b0,12'h018,32'h0,32'h00AA0055,4'd7},
    {1'b0,12'h000,32'h0,32'h00000000,4'd9},  // R9 unmapped
    {1'b1,12'h004,32'hFFFFFFFF,32'h0,4'd9},
    {1'b0,12'h004,32'h0,32'h00000000,4'd9},
    {1'b1,12'hD20,32'h000290FF,32'h0,4'd9},
    {1'b0,12'hD20,32'h0,32'h00000000,4'd9},
    {1'b0,12'h02C,32'h0,32'h0000AAAA,4'd9},
    {1'b1,12'hD1C,32'h000290E7,32'h0,4'd8},  // R8 last word
    {1'b0,12'hD1C,32'h0,32'h000290E7,4'd8},
    {1'b1,12'h02C,32'h0000AAAB,32'h0,4'd2},
    {1'b0,12'h02C,32'h0,32'h0000AAAB,4'd2},
    {1'b1,12'h030,32'h00029000,32'h0,4'd3},
    {1'b0,12'h030,32'h0,32'h000290A3,4'd3},
    {1'b0,12'h02C,32'h0,32'h0001AAAB,4'd3}
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] r, output logic rdy);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    rdy = rsp_ready; r = rsp_rdata;
    req_valid = 0; req_write = 0;
  endtask

  function automatic logic [31:0] slot(input logic [NREG*5-1:0] bus, input int k);
    return 32'(bus[k*5 +: 5]);
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic rdy;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R1 reset outputs
    chk(1, "ready after reset", 32'(rsp_ready), 32'd0);
    chk(1, "coarse bus zero", 32'(|dly_coarse), 32'd0);
    chk(1, "fine bus zero", 32'(|dly_fine), 32'd0);

    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i][80], VECS[i][79:68], VECS[i][67:36], r, rdy);
      chk(10, "ready", 32'(rdy), 32'd1);
      if (!VECS[i][80]) chk(int'(VECS[i][3:0]), $sformatf("read %h", VECS[i][79:68]), r, VECS[i][35:4]);
    end

    // R8 code outputs by slot
    chk(8, "slot0 coarse", slot(dly_coarse, 0), 32'd5);
    chk(8, "slot0 fine", slot(dly_fine, 0), 32'd3);
    chk(8, "slot1 coarse", slot(dly_coarse, 1), 32'd0);
    chk(8, "slot2 coarse", slot(dly_coarse, 2), 32'd2);
    chk(8, "slot2 fine", slot(dly_fine, 2), 32'd2);
    chk(8, "slot827 coarse", slot(dly_coarse, NREG-1), 32'd7);
    chk(8, "slot827 fine", slot(dly_fine, NREG-1), 32'd7);

    // R10 write returns zero, idle ready low
    xfer(1'b1, 12'h014, 32'h0, r, rdy);
    chk(10, "write rdata", r, 32'h0);
    @(negedge clk);
    chk(10, "idle ready", 32'(rsp_ready), 32'd0);

    // R1 reset again restores defaults
    rst_n = 0;
    @(negedge clk) rst_n = 1;
    chk(1, "slot2 coarse after reset", slot(dly_coarse, 2), 32'd0);
    xfer(1'b0, 12'h038, 32'h0, r, rdy);
    chk(1, "pad word after reset", r, 32'h00029000);
    xfer(1'b0, 12'h02C, 32'h0, r, rdy);
    chk(1, "lock after reset", r, 32'h0000AAAB);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule